// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the 256-byte configuration header of a single endpoint function with a type-0 layout. One access port carries reads and writes of one, two or four bytes at any byte offset. A write passes each byte through its own writable-bit mask before it lands. The masks are fixed when the design is elaborated. They come from the header layout rules and from the region sizes of the six base address registers and the expansion ROM register. Software can therefore size a region by writing all ones and reading the value back.

After every write the block compares the old and new contents of the address-decode state: the 24 base-address bytes, and the I/O and memory decode enables in the command byte. It emits a one-cycle remap pulse only when one of them really changed. A decoder elsewhere uses this pulse to rebuild its windows. Reads return little-endian data one cycle after the request.

Top module: `cfg_hdr_regs`

## Requirements
- R1: While reset is held and after it is released, offsets 0x00-0x01 read the vendor parameter, 0x02-0x03 the device parameter, 0x08 the revision, 0x09-0x0B the class code and 0x0E the header-type parameter. Each base-address word with a nonzero size holds its type parameter, and every other byte reads zero.
- R2: Each written byte is stored as (old AND NOT mask) OR (new AND mask), where mask is that byte's fixed writable-bit mask.
- R3: The access size `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Write data bytes go least-significant first to consecutive offsets. Lanes that would pass offset 0xFF are dropped, with no wrap to 0x00.
- R4: In the command byte at 0x04 only bits 0 (I/O decode), 1 (memory decode) and 2 (bus mastering) are writable, and byte 0x05 is read-only.
- R5: The bytes at 0x0C and 0x3C, and every byte from 0x40 to 0xFF, are fully writable.
- R6: The identity, revision, class-code and header-type bytes never change on a write.
- R7: Base-address word n sits at 0x10+4n (n = 0..5) with writable mask NOT(size-1). Its low bits keep the type value. A word whose size is zero has an all-zero mask and reads zero.
- R8: The expansion ROM word at 0x30 has writable mask NOT(size-1) with bit 0 (ROM enable) also writable.
- R9: `remap_pulse` is high for exactly the cycle after a write that changed any byte in 0x10-0x27 or toggled command bit 0 or 1. Writes that change nothing there, change only bus mastering, or touch the ROM word leave it low.
- R10: A read returns on `rd_data` with `rd_valid` one cycle after the request, byte at the given offset in bits 7:0. Lanes beyond the request size or past 0xFF read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Starting byte offset |
| acc_size | input | 2 | Size code: 0 = 1, 1 = 2, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, least-significant byte to the lowest offset |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, little-endian |
| remap_pulse | output | 1 | One-cycle pulse after a write that changed the address decode |

## Verification
A wrong mask or a merge fault shows at the next read of the same offset, one cycle after that read request. It appears as a bit that moved when it should not have, or a sizing readback with wrong low bits. A stray or missing remap pulse shows one cycle after the write that caused it. The bench writes each decode-relevant field twice with the same value so that a pulse from the second, unchanging write is also caught. A lane fault in the offset logic shows as bytes at the wrong offset or a wrap into the identity bytes. The bench sees this on the first read that spans the boundary.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CFG_BYTES = 256;
  localparam int CFG_LANES = 4;
  localparam int CFG_NBARS = 6;
  localparam logic [7:0] CMD_OFF  = 8'h04;
  localparam logic [7:0] BAR_LO   = 8'h10;
  localparam logic [7:0] BAR_HI   = 8'h27;
  localparam logic [7:0] ROM_LO   = 8'h30;
  localparam logic [7:0] ROM_HI   = 8'h33;
  localparam logic [7:0] OPEN_LO  = 8'h40;

  typedef logic [CFG_NBARS-1:0][31:0] bar_vec_t;

  function automatic logic [7:0] cfg_wmask(input logic [7:0] off,
                                           input bar_vec_t bsz,
                                           input logic [31:0] rom_sz);
    logic [7:0]  r;
    logic [7:0]  idx;
    logic [31:0] m;
    r   = 8'h00;
    idx = (off - BAR_LO) >> 2;
    m   = 32'h0;
    if (off >= OPEN_LO) r = 8'hFF;
    else if (off == CMD_OFF) r = 8'h07;
    else if (off == 8'h0C || off == 8'h3C) r = 8'hFF;
    else if (off >= BAR_LO && off <= BAR_HI) begin
      if (bsz[idx[2:0]] != 32'h0) m = ~(bsz[idx[2:0]] - 32'h1);
      r = m[{off[1:0], 3'b000} +: 8];
    end else if (off >= ROM_LO && off <= ROM_HI) begin
      if (rom_sz != 32'h0) m = ~(rom_sz - 32'h1) | 32'h1;
      r = m[{off[1:0], 3'b000} +: 8];
    end
    return r;
  endfunction

  function automatic logic [7:0] cfg_rstval(input logic [7:0] off,
                                            input logic [15:0] vid,
                                            input logic [15:0] did,
                                            input logic [7:0] rev,
                                            input logic [23:0] cls,
                                            input logic [7:0] hdr,
                                            input bar_vec_t bsz,
                                            input bar_vec_t bty);
    logic [7:0] r;
    logic [7:0] idx;
    r   = 8'h00;
    idx = (off - BAR_LO) >> 2;
    case (off)
      8'h00: r = vid[7:0];
      8'h01: r = vid[15:8];
      8'h02: r = did[7:0];
      8'h03: r = did[15:8];
      8'h08: r = rev;
      8'h09: r = cls[7:0];
      8'h0A: r = cls[15:8];
      8'h0B: r = cls[23:16];
      8'h0E: r = hdr;
      default: begin
        if (off >= BAR_LO && off <= BAR_HI && bsz[idx[2:0]] != 32'h0)
          r = bty[idx[2:0]][{off[1:0], 3'b000} +: 8];
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfg_hdr_lanes.sv
module cfg_hdr_lanes
  import cfg_hdr_pkg::*;
(
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [7:0]                   acc_off,
  input  logic [1:0]                   acc_size,
  input  logic [31:0]                  acc_wdata,
  output logic [CFG_LANES-1:0]         lane_act,
  output logic [CFG_LANES-1:0]         lane_we,
  output logic [CFG_LANES-1:0][7:0]    lane_addr,
  output logic [CFG_LANES-1:0][7:0]    lane_data
);
  logic [2:0] len;

  always_comb begin
    case (acc_size)
      2'd0:    len = 3'd1;
      2'd1:    len = 3'd2;
      default: len = 3'd4;
    endcase
  end

  for (genvar l = 0; l < CFG_LANES; l++) begin : g_lane
    logic [8:0] sum;
    assign sum          = {1'b0, acc_off} + 9'(l);
    assign lane_addr[l] = sum[7:0];
    assign lane_act[l]  = (3'(l) < len) && !sum[8];
    assign lane_we[l]   = lane_act[l] && acc_valid && acc_write;
    assign lane_data[l] = acc_wdata[8*l +: 8];
  end
endmodule

// File: rtl/cfg_hdr_store.sv
module cfg_hdr_store
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR   = 16'hABCD,
  parameter logic [15:0] DEVICE   = 16'h1234,
  parameter logic [7:0]  REVISION = 8'h05,
  parameter logic [23:0] CLASS    = 24'h020000,
  parameter logic [7:0]  HDR_TYPE = 8'h80,
  parameter bar_vec_t    BAR_SIZE = '0,
  parameter bar_vec_t    BAR_TYPE = '0,
  parameter logic [31:0] ROM_SIZE = 32'h0
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic [CFG_LANES-1:0]      lane_we,
  input  logic [CFG_LANES-1:0][7:0] lane_addr,
  input  logic [CFG_LANES-1:0][7:0] lane_data,
  output logic [CFG_LANES-1:0][7:0] lane_old,
  output logic [CFG_LANES-1:0][7:0] lane_new
);
  logic [7:0] mem [CFG_BYTES];
  logic [CFG_LANES-1:0][7:0] lane_mask;

  for (genvar l = 0; l < CFG_LANES; l++) begin : g_merge
    always_comb begin
      lane_mask[l] = cfg_wmask(lane_addr[l], BAR_SIZE, ROM_SIZE);
      lane_old[l]  = mem[lane_addr[l]];
      lane_new[l]  = (lane_old[l] & ~lane_mask[l]) | (lane_data[l] & lane_mask[l]);
    end
  end

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    localparam logic [7:0] RST = cfg_rstval(8'(b), VENDOR, DEVICE, REVISION,
                                            CLASS, HDR_TYPE, BAR_SIZE, BAR_TYPE);
    logic       en;
    logic [7:0] nxt;
    always_comb begin
      en  = 1'b0;
      nxt = mem[b];
      for (int l = 0; l < CFG_LANES; l++) begin
        if (lane_we[l] && lane_addr[l] == 8'(b)) begin
          en  = 1'b1;
          nxt = lane_new[l];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  mem[b] <= RST;
      else if (en)  mem[b] <= nxt;
    end
  end

  // R4: reserved command bits and the upper command byte stay clear
  p_cmd_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem[4][7:3] == 5'h0) && (mem[5] == 8'h00));

  // R6: identity bytes never move
  p_id_stable_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ($stable(mem[0]) && $stable(mem[1]) && $stable(mem[2]) && $stable(mem[3])));
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR   = 16'hABCD,
  parameter logic [15:0] DEVICE   = 16'h1234,
  parameter logic [7:0]  REVISION = 8'h05,
  parameter logic [23:0] CLASS    = 24'h020000,
  parameter logic [7:0]  HDR_TYPE = 8'h80,
  parameter bar_vec_t    BAR_SIZE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0100, 32'h0000_1000},
  parameter bar_vec_t    BAR_TYPE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 32'h0000_0008},
  parameter logic [31:0] ROM_SIZE = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [7:0]  acc_off,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        remap_pulse
);
  logic rst_s1, rst_s2;
  logic [CFG_LANES-1:0]      lane_act, lane_we, lane_hit;
  logic [CFG_LANES-1:0][7:0] lane_addr, lane_data, lane_old, lane_new;
  logic        rd_req, remap_nxt;
  logic [31:0] rd_nxt;
  logic        rd_valid_q, remap_q;
  logic [31:0] rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  cfg_hdr_lanes u_lanes (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_off   (acc_off),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .lane_act  (lane_act),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (lane_data)
  );

  cfg_hdr_store #(
    .VENDOR(VENDOR), .DEVICE(DEVICE), .REVISION(REVISION), .CLASS(CLASS),
    .HDR_TYPE(HDR_TYPE), .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .ROM_SIZE(ROM_SIZE)
  ) u_store (
    .clk       (clk),
    .rst_ni    (rst_s2),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .lane_old  (lane_old),
    .lane_new  (lane_new)
  );

  for (genvar l = 0; l < CFG_LANES; l++) begin : g_dec
    logic [7:0] diff;
    assign diff = lane_old[l] ^ lane_new[l];
    assign lane_hit[l] = lane_we[l] &&
      (((lane_addr[l] >= BAR_LO) && (lane_addr[l] <= BAR_HI) && (diff != 8'h00)) ||
       ((lane_addr[l] == CMD_OFF) && (diff[1:0] != 2'b00)));
  end

  always_comb begin
    rd_req    = acc_valid && !acc_write;
    remap_nxt = |lane_hit;
    for (int l = 0; l < CFG_LANES; l++)
      rd_nxt[8*l +: 8] = lane_act[l] ? lane_old[l] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      rd_valid_q <= 1'b0;
      remap_q    <= 1'b0;
      rd_data_q  <= 32'h0;
    end else begin
      rd_valid_q <= rd_req;
      remap_q    <= remap_nxt;
      if (rd_req) rd_data_q <= rd_nxt;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign remap_pulse = remap_q;

  // R10: every read request answers on the next cycle
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_s2)
    (acc_valid && !acc_write) |=> rd_valid);

  // R9: a remap pulse only follows a write
  p_remap_cause_r9: assert property (@(posedge clk) disable iff (!rst_s2)
    remap_pulse |-> $past(acc_valid && acc_write));
endmodule

// File: tb/test_cfg_hdr_regs.sv
module test_cfg_hdr_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [7:0]  acc_off;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic        rd_valid, remap_pulse;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cfg_hdr_regs i_cfg_hdr_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .remap_pulse(remap_pulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // driver: issue a read and push its expected result
  task automatic do_read(input logic [7:0] off, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc_valid = 1'b1; acc_write = 1'b0; acc_off = off; acc_size = sz; acc_wdata = '0;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // driver: issue a write and check the remap pulse in the following cycle
  task automatic do_write(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] d,
                          input bit exp_remap, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_off = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check(remap_pulse == exp_remap, tag, 32'(remap_pulse), 32'(exp_remap));
  endtask

  // monitor: pop and compare as read results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected rd_valid", rd_data, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_off = '0; acc_size = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0 && remap_pulse == 1'b0, "R1 outputs idle in reset",
          {30'h0, rd_valid, remap_pulse}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_read(8'h00, 2'd2, 32'h1234ABCD, "R1 vendor/device after reset");
    do_read(8'h08, 2'd2, 32'h02000005, "R1 revision/class after reset");
    do_read(8'h0C, 2'd2, 32'h00800000, "R1 header type after reset");
    do_read(8'h10, 2'd2, 32'h00000008, "R1 BAR0 type after reset");
    do_read(8'h14, 2'd2, 32'h00000001, "R1 BAR1 type after reset");
    do_read(8'h40, 2'd2, 32'h00000000, "R1 open area zero after reset");

    do_write(8'h00, 2'd2, 32'hFFFFFFFF, 1'b0, "R9 no remap on id write");
    do_read(8'h00, 2'd2, 32'h1234ABCD, "R6 id bytes unchanged");
    do_write(8'h08, 2'd3, 32'h0, 1'b0, "R9 no remap on class write");
    do_read(8'h08, 2'd3, 32'h02000005, "R6 class unchanged, size code 3");

    do_write(8'h04, 2'd1, 32'h0000FFFF, 1'b1, "R9 remap on decode enable toggle");
    do_read(8'h04, 2'd1, 32'h00000007, "R4 command mask");
    do_write(8'h04, 2'd0, 32'h00000007, 1'b0, "R9 no remap on same command");
    do_write(8'h04, 2'd0, 32'h00000003, 1'b0, "R9 no remap on bus master only");
    do_read(8'h04, 2'd0, 32'h00000003, "R4 bus master cleared");

    do_write(8'h0C, 2'd0, 32'h0000005A, 1'b0, "R9 no remap cache line");
    do_read(8'h0C, 2'd2, 32'h0080005A, "R5 cache line writable");
    do_write(8'h3C, 2'd1, 32'h0000FF0B, 1'b0, "R9 no remap int line");
    do_read(8'h3C, 2'd1, 32'h0000000B, "R5 interrupt line writable, 0x3D fixed");
    do_write(8'h80, 2'd1, 32'h0000BEEF, 1'b0, "R9 no remap open area");
    do_read(8'h80, 2'd1, 32'h0000BEEF, "R5 open area writable");

    do_write(8'h10, 2'd2, 32'hFFFFFFFF, 1'b1, "R9 remap on BAR0 change");
    do_read(8'h10, 2'd2, 32'hFFFFF008, "R7 BAR0 sizing");
    do_write(8'h10, 2'd2, 32'hFFFFFFFF, 1'b0, "R9 no remap on BAR0 rewrite");
    do_write(8'h14, 2'd2, 32'hFFFFFFFF, 1'b1, "R9 remap on BAR1 change");
    do_read(8'h14, 2'd2, 32'hFFFFFF01, "R7 BAR1 sizing");
    do_write(8'h18, 2'd2, 32'hFFFFFFFF, 1'b0, "R9 no remap unsized BAR2");
    do_read(8'h18, 2'd2, 32'h00000000, "R7 unsized BAR2 reads zero");
    do_write(8'h11, 2'd0, 32'h00000000, 1'b1, "R9 remap on BAR0 byte write");
    do_read(8'h10, 2'd2, 32'hFFFF0008, "R2 merge of single BAR byte");

    do_write(8'h30, 2'd2, 32'hFFFFFFFF, 1'b0, "R9 no remap on ROM word");
    do_read(8'h30, 2'd2, 32'hFFFF0001, "R8 ROM sizing with enable bit");

    do_write(8'h41, 2'd2, 32'h44332211, 1'b0, "R9 no remap unaligned");
    do_read(8'h40, 2'd2, 32'h33221100, "R3 unaligned lanes LSB first");
    do_read(8'h44, 2'd0, 32'h00000044, "R3 fourth lane at next word");
    do_write(8'hFE, 2'd2, 32'hDDCCBBAA, 1'b0, "R9 no remap at end");
    do_read(8'hFC, 2'd2, 32'hBBAA0000, "R3 bytes before end stored");
    do_read(8'h00, 2'd0, 32'h000000CD, "R3 no wrap into offset 0");
    do_read(8'hFE, 2'd2, 32'h0000BBAA, "R10 lanes past end read zero");
    do_read(8'h02, 2'd1, 32'h00001234, "R10 two-byte little-endian read");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads answered", 32'(exp_q.size()), 32'h0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule